// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the strobes of an asynchronous DRAM array for two jobs: bringing the array up after power-on and keeping every row refreshed afterwards. After reset it keeps the array idle for a parameterized startup pause of 200 µs by default. It then runs a fixed train of eight warm-up refresh cycles and only then raises `init_done`. Every refresh is the internal-counter kind, so no address is driven. The column strobe drops first, the row strobe follows, the row strobe's low window is held for its minimum width, and both rise together into a precharge gap. The write-enable strobe stays high for the whole cycle.

After start-up, an interval timer derived from the clock rate, the row count and the retention period queues one refresh per interval. With the defaults (100 MHz, 4096 rows, 64 ms) that is one every 1562 cycles. Queued refreshes are served through a request/grant handshake with the access sequencer. The controller raises `ref_req`. The sequencer answers with `ref_gnt` once its current access has ended and keeps it high while `ref_req` stays high. The controller then runs all queued refreshes back to back. Up to eight refreshes may wait. With eight waiting, `acc_hold` forces the sequencer to stop starting new accesses and further interval ticks are dropped.

The state machine has these states. PAUSE counts the startup delay. IDLE waits for work and a grant. PRE is an all-high setup slot that also gives write-enable its setup time. CSR has the column strobe low while the row strobe is still high. RASLO has both strobes low. RP is the precharge with both strobes high. The transitions are:
- PAUSE→PRE when the delay ends.
- IDLE→PRE on a grant with work queued.
- PRE→CSR→RASLO→RP, each when its cycle count runs out.
- RP→PRE for the next warm-up cycle, or for the next queued refresh.
- RP→IDLE after the eighth warm-up cycle, or when the queue is empty.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset is released, no strobe falls for at least PAUSE_US×CLK_MHZ cycles. Then exactly 8 refresh cycles run without any grant, and `init_done` rises only after the eighth. Until then `acc_hold` and `ref_own` are 1 and `ref_req` is 0.
- R2: Once `init_done` is 1, one refresh is queued every (RETENTION_US×CLK_MHZ)/ROWS cycles. When each request is served at once, successive rising edges of `ref_req` are exactly that far apart.
- R3: In every refresh, `cas_n` goes low while `ras_n` is high and stays low alone for ceil(T_CSR_NS×CLK_MHZ/1000) cycles before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low and rises in the same cycle as `ras_n`.
- R4: `we_n` is 1 in every cycle, including all refresh cycles.
- R5: `ras_n` stays low for exactly ceil(T_RAS_NS×CLK_MHZ/1000) cycles. Between two refreshes of one burst, both strobes stay high for RP cycles plus PRE cycles (4 at 100 MHz).
- R6: After init, the strobes do not move while `ref_gnt` is 0. A refresh starts the cycle after `ref_gnt` is seen with work queued. `ref_req` falls in the cycle after the last queued refresh ends.
- R7: Refreshes queue while no grant is given. A granted burst serves all of them, including ticks that arrive during the burst. The queue saturates at PEND_MAX (8), and ticks that arrive while it is full are lost.
- R8: `acc_hold` is 1 while the controller owns the strobes or while PEND_MAX refreshes are queued, and 0 otherwise after init.
- R9: While `rst_n` is 0 (asynchronous), `ras_n`, `cas_n` and `we_n` are 1, `init_done` and `ref_req` are 0, and `acc_hold` and `ref_own` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Sequencer grants the strobes to refresh |
| ref_req | output | 1 | Refresh work queued or in progress |
| acc_hold | output | 1 | Sequencer must not begin a new access |
| ref_own | output | 1 | Controller currently drives the strobes |
| init_done | output | 1 | Startup pause and warm-up train completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
A wrong state shows on the strobes within one refresh cycle. A slot counter off by one changes the CAS lead, the RAS width or the precharge gap by one cycle, and a wrong state order breaks the CAS-first rule at the very next RAS fall. A wrong queue count shows up only later, as a burst with one refresh too many or too few, or as `acc_hold` rising at the wrong tick. That takes up to eight refresh intervals, so the bench withholds the grant long enough to fill the queue and overflow it before it checks. A faulty interval timer shows as the spacing between successive `ref_req` edges.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_PRE,
        ST_CSR,
        ST_RASLO,
        ST_RP
    } ref_state_t;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/ref_tick_timer.sv
module ref_tick_timer #(
    parameter int unsigned INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);

    logic [TW-1:0] cnt;

    assign tick = en && (cnt == TW'(INTERVAL_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R2: two ticks are never adjacent
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ref_pend_counter.sv
module ref_pend_counter #(
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic done,
    output logic pend_nz,
    output logic pend_full,
    output logic pend_more
);
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [PW-1:0] cnt;
    logic          inc;
    logic          dec;

    assign pend_nz   = (cnt != '0);
    assign pend_full = (cnt == PW'(PEND_MAX));
    assign pend_more = (cnt > PW'(1)) || tick;
    assign inc       = tick && (!pend_full || done);
    assign dec       = done && pend_nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (inc && !dec)    cnt <= cnt + 1'b1;
        else if (dec && !inc)    cnt <= cnt - 1'b1;
    end

    // R7: a tick arriving at a full queue is dropped
    assert_pend_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_full && tick && !done) |=> pend_full);

    // R7: serving the last queued refresh empties the queue
    assert_pend_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tick && !pend_more) |=> !pend_nz);

endmodule

// File: rtl/ref_cbr_fsm.sv
module ref_cbr_fsm
    import dram_ref_pkg::*;
#(
    parameter int unsigned STARTUP_CYC = 20000,
    parameter int unsigned WARMUP      = 8,
    parameter int unsigned PRE_CYC     = 1,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_CYC     = 5,
    parameter int unsigned RP_CYC      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic pend_nz,
    input  logic pend_more,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic own,
    output logic done,
    output logic init_done
);
    localparam int unsigned SLOT_MAX =
        (PRE_CYC > CSR_CYC ? PRE_CYC : CSR_CYC) > (RAS_CYC > RP_CYC ? RAS_CYC : RP_CYC) ?
        (PRE_CYC > CSR_CYC ? PRE_CYC : CSR_CYC) : (RAS_CYC > RP_CYC ? RAS_CYC : RP_CYC);
    localparam int unsigned LEN_MAX = STARTUP_CYC > SLOT_MAX ? STARTUP_CYC : SLOT_MAX;
    localparam int CW = $clog2(LEN_MAX + 1);
    localparam int WW = $clog2(WARMUP + 1);

    ref_state_t    state;
    logic [CW-1:0] wait_cnt;
    logic [CW-1:0] phase_len;
    logic [WW-1:0] warm_cnt;
    logic          init_q;
    logic          last;

    always_comb begin
        unique case (state)
            ST_PAUSE: phase_len = CW'(STARTUP_CYC - 1);
            ST_PRE:   phase_len = CW'(PRE_CYC - 1);
            ST_CSR:   phase_len = CW'(CSR_CYC - 1);
            ST_RASLO: phase_len = CW'(RAS_CYC - 1);
            ST_RP:    phase_len = CW'(RP_CYC - 1);
            default:  phase_len = '0;
        endcase
    end

    assign last = (wait_cnt == phase_len);

    // State register and slot counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_PAUSE;
            wait_cnt <= '0;
            warm_cnt <= '0;
            init_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_PAUSE: begin
                    if (last) begin state <= ST_PRE; wait_cnt <= '0; end
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_IDLE: begin
                    if (gnt && pend_nz) begin state <= ST_PRE; wait_cnt <= '0; end
                end
                ST_PRE: begin
                    if (last) begin state <= ST_CSR; wait_cnt <= '0; end
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_CSR: begin
                    if (last) begin state <= ST_RASLO; wait_cnt <= '0; end
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_RASLO: begin
                    if (last) begin state <= ST_RP; wait_cnt <= '0; end
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_RP: begin
                    if (last) begin
                        wait_cnt <= '0;
                        if (!init_q) begin
                            warm_cnt <= warm_cnt + 1'b1;
                            if (warm_cnt == WW'(WARMUP - 1)) begin
                                init_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                state <= ST_PRE;
                            end
                        end else begin
                            state <= pend_more ? ST_PRE : ST_IDLE;
                        end
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (state)
            ST_CSR:   cas_n = 1'b0;
            ST_RASLO: begin ras_n = 1'b0; cas_n = 1'b0; end
            default:  ;
        endcase
    end

    assign we_n      = 1'b1;
    assign own       = !init_q || (state inside {ST_PRE, ST_CSR, ST_RASLO, ST_RP});
    assign done      = (state == ST_RP) && last && init_q;
    assign init_done = init_q;

    // R3: the column strobe already led by a cycle when the row strobe falls
    assert_cas_before_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R3: column strobe held low throughout the row strobe low window
    assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5: row strobe low window lasts more than one cycle
    assert_ras_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);

    // R5: precharge lasts more than one cycle
    assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    // R6: after init, a refresh only starts under grant
    assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && init_q) |-> gnt);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned ROWS         = 4096,
    parameter int unsigned RETENTION_US = 64000,
    parameter int unsigned PAUSE_US     = 200,
    parameter int unsigned WARMUP       = 8,
    parameter int unsigned PEND_MAX     = 8,
    parameter int unsigned T_PRE_NS     = 10,
    parameter int unsigned T_CSR_NS     = 10,
    parameter int unsigned T_RAS_NS     = 50,
    parameter int unsigned T_RP_NS      = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic acc_hold,
    output logic ref_own,
    output logic init_done,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int unsigned INTERVAL_CYC = (RETENTION_US * CLK_MHZ) / ROWS;
    localparam int unsigned STARTUP_CYC  = PAUSE_US * CLK_MHZ;
    localparam int unsigned PRE_CYC      = ns_to_cyc(T_PRE_NS, CLK_MHZ);
    localparam int unsigned CSR_CYC      = ns_to_cyc(T_CSR_NS, CLK_MHZ);
    localparam int unsigned RAS_CYC      = ns_to_cyc(T_RAS_NS, CLK_MHZ);
    localparam int unsigned RP_CYC       = ns_to_cyc(T_RP_NS, CLK_MHZ);

    logic tick;
    logic done;
    logic pend_nz;
    logic pend_full;
    logic pend_more;
    logic own;
    logic init_q;

    ref_tick_timer #(.INTERVAL_CYC(INTERVAL_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_q),
        .tick  (tick)
    );

    ref_pend_counter #(.PEND_MAX(PEND_MAX)) i_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .done      (done),
        .pend_nz   (pend_nz),
        .pend_full (pend_full),
        .pend_more (pend_more)
    );

    ref_cbr_fsm #(
        .STARTUP_CYC (STARTUP_CYC),
        .WARMUP      (WARMUP),
        .PRE_CYC     (PRE_CYC),
        .CSR_CYC     (CSR_CYC),
        .RAS_CYC     (RAS_CYC),
        .RP_CYC      (RP_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (ref_gnt),
        .pend_nz   (pend_nz),
        .pend_more (pend_more),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .own       (own),
        .done      (done),
        .init_done (init_q)
    );

    assign init_done = init_q;
    assign ref_own   = own;
    assign ref_req   = init_q && (pend_nz || own);
    assign acc_hold  = !init_q || pend_full || own;

endmodule

// File: tb/test_dram_refresh_ctrl.sv
module test_dram_refresh_ctrl;

    localparam int EXP_PAUSE    = 200;  // 2 us at 100 MHz
    localparam int EXP_INTERVAL = 100;  // 16 us * 100 / 16 rows
    localparam int EXP_CSR      = 1;
    localparam int EXP_RAS      = 5;
    localparam int EXP_GAP      = 4;    // RP 3 + PRE 1
    localparam int EXP_WARM     = 8;
    localparam int EXP_PEND     = 8;

    // grant latency (cycles after ref_req seen) and expected burst length
    localparam int VLAT [6] = '{0, 2, 7, 30, 130, 250};
    localparam int VEXP [6] = '{1, 1, 1, 1, 2, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, acc_hold, ref_own, init_done, ras_n, cas_n, we_n;

    int checks = 0;
    int bad = 0;
    int cyc = 0;

    int w_cycles, w_first;
    bit w_lead_bad, w_width_bad, w_gap_bad, w_we_bad, w_own_bad;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_ctrl #(
        .CLK_MHZ(100), .ROWS(16), .RETENTION_US(16), .PAUSE_US(2)
    ) i_dram_refresh_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .acc_hold(acc_hold), .ref_own(ref_own), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic watch_burst(input bit init_mode);
        logic pc, pr;
        int lead, low, high, k;
        w_cycles = 0; w_first = -1;
        w_lead_bad = 0; w_width_bad = 0; w_gap_bad = 0; w_we_bad = 0; w_own_bad = 0;
        lead = 0; low = 0; high = 0; k = 0;
        pc = cas_n; pr = ras_n;
        forever begin
            @(negedge clk);
            k++;
            if (init_mode ? (init_done === 1'b1) : (ref_req === 1'b0)) break;
            if (k > 3000) begin w_lead_bad = 1; break; end
            if (we_n !== 1'b1) w_we_bad = 1;
            if (acc_hold !== 1'b1 || ref_own !== 1'b1) w_own_bad = 1;
            if (init_mode && ref_req !== 1'b0) w_own_bad = 1;
            if (pc && !cas_n) begin
                if (!ras_n) w_lead_bad = 1;
                if (w_first < 0) w_first = k;
                if (w_cycles > 0 && high != EXP_GAP) w_gap_bad = 1;
                lead = 1;
            end else if (!cas_n && ras_n) begin
                lead++;
            end
            if (pr && !ras_n) begin
                if (lead != EXP_CSR || cas_n) w_lead_bad = 1;
                low = 1;
            end else if (!ras_n) begin
                low++;
                if (cas_n) w_lead_bad = 1;
            end
            if (!pr && ras_n) begin
                if (low != EXP_RAS) w_width_bad = 1;
                if (!cas_n) w_lead_bad = 1;
                w_cycles++;
                high = 1;
            end else if (ras_n && cas_n) begin
                high++;
            end
            pc = cas_n; pr = ras_n;
        end
    endtask

    task automatic burst_checks(input int exp_n, input string tag);
        chk(w_cycles == exp_n, "R7", {tag, " burst length"}, w_cycles, exp_n);
        chk(!w_lead_bad, "R3", {tag, " CAS lead/hold"}, w_lead_bad, 0);
        chk(!w_width_bad, "R5", {tag, " RAS low width"}, w_width_bad, 0);
        chk(!w_gap_bad, "R5", {tag, " precharge gap"}, w_gap_bad, 0);
        chk(!w_we_bad, "R4", {tag, " we_n high"}, w_we_bad, 0);
        chk(!w_own_bad, "R8", {tag, " hold/own during refresh"}, w_own_bad, 0);
    endtask

    task automatic wait_req();
        while (ref_req !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        checks++; bad++;
        $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int t1, t2;
        bit stray;
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(ras_n === 1 && cas_n === 1 && we_n === 1, "R9", "strobes idle in reset",
            {ras_n, cas_n, we_n}, 3'b111);
        chk(init_done === 0 && ref_req === 0, "R9", "init_done/ref_req low in reset",
            {init_done, ref_req}, 0);
        chk(acc_hold === 1 && ref_own === 1, "R9", "hold/own high in reset",
            {acc_hold, ref_own}, 2'b11);

        // R1 startup pause and warm-up train
        rst_n = 1'b1;
        watch_burst(1'b1);
        chk(w_first > EXP_PAUSE && w_first <= EXP_PAUSE + 3, "R1", "first CAS fall after pause",
            w_first, EXP_PAUSE + 1);
        chk(w_cycles == EXP_WARM, "R1", "warm-up cycle count", w_cycles, EXP_WARM);
        chk(!w_own_bad, "R1", "no request and hold during init", w_own_bad, 0);
        chk(!w_lead_bad && !w_width_bad && !w_gap_bad, "R3", "warm-up strobe shape", 1, 0);
        chk(!w_we_bad, "R4", "we_n high during init", w_we_bad, 0);
        chk(acc_hold === 0 && ref_req === 0, "R8", "released after init",
            {acc_hold, ref_req}, 0);

        // vector table: grant latency versus burst length
        for (int i = 0; i < 6; i++) begin
            wait_req();
            chk(acc_hold === 0, "R8", "no hold with short queue", acc_hold, 0);
            stray = 0;
            for (int j = 0; j < VLAT[i]; j++) begin
                @(negedge clk);
                if (!ras_n || !cas_n || !ref_req || ref_own) stray = 1;
            end
            chk(!stray, "R6", "strobes still while waiting for grant", stray, 0);
            ref_gnt = 1'b1;
            watch_burst(1'b0);
            ref_gnt = 1'b0;
            burst_checks(VEXP[i], $sformatf("vec%0d", i));
        end

        // R2 interval between requests
        wait_req();
        t1 = cyc;
        ref_gnt = 1'b1;
        watch_burst(1'b0);
        ref_gnt = 1'b0;
        wait_req();
        t2 = cyc;
        chk(t2 - t1 == EXP_INTERVAL, "R2", "refresh interval", t2 - t1, EXP_INTERVAL);

        // R7/R8 saturation: no grant until queue overflows
        stray = 0;
        while (acc_hold !== 1'b1) begin
            @(negedge clk);
            if (!ras_n || !cas_n) stray = 1;
        end
        chk(cyc - t2 == (EXP_PEND - 1) * EXP_INTERVAL, "R8", "hold at full queue",
            cyc - t2, (EXP_PEND - 1) * EXP_INTERVAL);
        while (cyc - t2 < 850) begin
            @(negedge clk);
            if (!ras_n || !cas_n || !acc_hold) stray = 1;
        end
        chk(!stray, "R6", "no refresh without grant while full", stray, 0);
        ref_gnt = 1'b1;
        watch_burst(1'b0);
        ref_gnt = 1'b0;
        burst_checks(EXP_PEND + 1, "saturated");
        chk(acc_hold === 0, "R8", "hold released after drain", acc_hold, 0);

        // R9 asynchronous reset in the middle of a refresh
        wait_req();
        ref_gnt = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        ref_gnt = 1'b0;
        #1;
        chk(ras_n === 1 && cas_n === 1 && we_n === 1, "R9", "strobes idle on reset mid-cycle",
            {ras_n, cas_n, we_n}, 3'b111);
        chk(init_done === 0 && ref_req === 0 && acc_hold === 1, "R9", "init cleared on reset",
            {init_done, ref_req, acc_hold}, 3'b001);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule